// File: doc/BRIEF.md
# Merging Store Buffer with Read-Miss Bypass

This block sits between a write-through data cache and the next memory level. The processor posts stores into it and keeps running. Each store names a byte address, one data word and per-byte enables. The buffer keeps a few block-sized entries. Each entry holds a block address, the block's data words and one valid bit per byte. A store to a block that already has a live entry is folded into that entry. A store to any other block takes a free entry. Eviction write-backs from a write-back cache can be posted the same way, one word at a time.

Entries leave in allocation order, one at a time, through a single registered command port to memory. The same port carries read misses. A pending read miss is checked against the block address of every live entry. If nothing matches, the read takes the port ahead of all queued writes. If an entry matches, writes keep draining in order until no live entry holds that block, and then the read goes out. A mode input makes every read miss wait until the buffer is completely empty.

Top module: `wbuf_merge`

## Requirements
- R1: After a synchronous active-high reset, the buffer is empty, `mem_cmd_valid` is low, and `st_ready` is high.
- R2: A store is accepted (`st_ready` high) in the same cycle whenever a free entry exists, or whenever its block matches a live entry that is not being handed to memory in that cycle.
- R3: A store that matches no eligible entry allocates a new entry. Block = `st_addr[31:4]`. Word index = `st_addr[3:2]`. `st_addr[1:0]` is ignored. Byte enable k writes bits [8k+7:8k] of the word. Word w occupies bits [32w+31:32w] of the line, and its byte k has mask bit 4w+k. Bytes that are not written read as zero with a clear mask bit.
- R4: A store whose block matches a live entry merges into that entry. Its enabled bytes overwrite the stored bytes and are ORed into the mask. The other bytes are untouched.
- R5: An entry that leaves for the command register in a cycle takes no merge in that cycle. A store to that block in that cycle opens a fresh entry.
- R6: Writes leave in allocation order. Each write is presented on the command port (`mem_cmd_write`=1, address = block with low 4 bits zero, line, mask) one cycle after it is chosen. It is held unchanged until `mem_cmd_ready` is seen.
- R7: In bypass mode (`cfg_drain_first`=0), a read miss whose block matches no live entry is granted (`rd_ready`) as soon as the command register is free, ahead of queued writes. It appears on the port one cycle later with `mem_cmd_write`=0, `rd_addr` unchanged, and zero line and mask.
- R8: In bypass mode, a read miss whose block matches a live entry is held off while writes drain in order. It is granted once no live entry matches.
- R9: With `cfg_drain_first`=1, a read miss is granted only when the buffer holds no entries.
- R10: When all entries are live and the store matches none that is eligible, `st_ready` is low and the store waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_drain_first | input | 1 | 1: read misses wait for an empty buffer |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data word |
| st_be | input | 4 | Store byte enables |
| rd_valid | input | 1 | Read-miss request |
| rd_ready | output | 1 | Read miss granted to the command port |
| rd_addr | input | 32 | Read-miss byte address |
| mem_cmd_valid | output | 1 | Command to memory valid |
| mem_cmd_ready | input | 1 | Memory takes the command |
| mem_cmd_write | output | 1 | 1 = write, 0 = read |
| mem_cmd_addr | output | 32 | Command byte address |
| mem_cmd_data | output | 128 | Write line data |
| mem_cmd_mask | output | 16 | Write byte mask |

## Verification
`st_ready` and `rd_ready` are decided in the same cycle as the request they answer. Every command on the memory port appears one clock after the cycle in which the arbiter picked it. The bench drives inputs at the falling edge and compares one nanosecond before the rising edge. The handshakes are therefore checked in the cycle of the request, and the command port is checked against the model's registered prediction from the previous cycle. A behavioural queue model steps once per clock and is compared on every cycle. Random stores, reads and memory back-pressure run over a handful of blocks, so merges, same-cycle hand-offs, conflicts and full-buffer stalls all occur in both modes.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    PICK_NONE  = 2'd0,
    PICK_READ  = 2'd1,
    PICK_WRITE = 2'd2
  } pick_e;
endpackage

// File: rtl/wbuf_cam.sv
module wbuf_cam #(
  parameter int DEPTH = 4,
  parameter int BLK_W = 28
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DEPTH-1:0]            live_i,
  input  logic [DEPTH-1:0][BLK_W-1:0] tags_i,
  input  logic [BLK_W-1:0]            key_i,
  output logic [DEPTH-1:0]            hit_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_o[i] = live_i[i] && (tags_i[i] == key_i);
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $countones(hit_o) <= 1); // R4
endmodule

// File: rtl/wbuf_slot.sv
module wbuf_slot #(
  parameter int BLK_W  = 28,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int BYTES  = WORD_W / 8,
  localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int LINE_W = WORDS * WORD_W,
  localparam int MASK_W = WORDS * BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_i,
  input  logic              merge_i,
  input  logic              clear_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [BYTES-1:0]  be_i,
  output logic              valid_o,
  output logic [BLK_W-1:0]  blk_o,
  output logic [LINE_W-1:0] line_o,
  output logic [MASK_W-1:0] mask_o
);
  logic              valid_q;
  logic [BLK_W-1:0]  blk_q;
  logic [LINE_W-1:0] line_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      blk_q   <= '0;
      line_q  <= '0;
      mask_q  <= '0;
    end else begin
      if (clear_i) valid_q <= 1'b0;
      if (alloc_i) begin
        valid_q <= 1'b1;
        blk_q   <= blk_i;
      end
      for (int w = 0; w < WORDS; w++) begin
        for (int b = 0; b < BYTES; b++) begin
          if (alloc_i) begin
            line_q[w*WORD_W + b*8 +: 8] <=
              ((wsel_i == WSEL_W'(w)) && be_i[b]) ? data_i[b*8 +: 8] : 8'h00;
            mask_q[w*BYTES + b] <= (wsel_i == WSEL_W'(w)) && be_i[b];
          end else if (merge_i && (wsel_i == WSEL_W'(w)) && be_i[b]) begin
            line_q[w*WORD_W + b*8 +: 8] <= data_i[b*8 +: 8];
            mask_q[w*BYTES + b]         <= 1'b1;
          end
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign blk_o   = blk_q;
  assign line_o  = line_q;
  assign mask_o  = mask_q;

  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (rst)
    alloc_i |-> !valid_q); // R3
  AST_MERGE_LIVE: assert property (@(posedge clk) disable iff (rst)
    merge_i |-> (valid_q && !clear_i && !alloc_i)); // R5
endmodule

// File: rtl/wbuf_merge.sv
module wbuf_merge
  import wbuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int DEPTH  = 4,
  localparam int BYTES  = WORD_W / 8,
  localparam int LANE_W = $clog2(BYTES),
  localparam int OFF_W  = $clog2(WORDS * BYTES),
  localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int LINE_W = WORDS * WORD_W,
  localparam int MASK_W = WORDS * BYTES,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_drain_first,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [WORD_W-1:0] st_data,
  input  logic [BYTES-1:0]  st_be,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_write,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic [LINE_W-1:0] mem_cmd_data,
  output logic [MASK_W-1:0] mem_cmd_mask
);
  // entry state
  logic [DEPTH-1:0]             slot_valid;
  logic [DEPTH-1:0][BLK_W-1:0]  slot_blk;
  logic [DEPTH-1:0][LINE_W-1:0] slot_line;
  logic [DEPTH-1:0][MASK_W-1:0] slot_mask;
  logic [PTR_W-1:0]             head_q, tail_q;
  logic [CNT_W-1:0]             count_q;

  // command register
  logic              cmd_valid_q, cmd_write_q;
  logic [ADDR_W-1:0] cmd_addr_q;
  logic [LINE_W-1:0] cmd_line_q;
  logic [MASK_W-1:0] cmd_mask_q;

  logic [BLK_W-1:0]  st_blk, rd_blk;
  logic [WSEL_W-1:0] st_wsel;
  logic [DEPTH-1:0]  st_hit, rd_hit, st_merge, head_onehot;
  logic              cmd_free, rd_go, pop, merge_any, st_fire, alloc, empty, full;
  pick_e             pick;

  assign st_blk  = st_addr[ADDR_W-1:OFF_W];
  assign rd_blk  = rd_addr[ADDR_W-1:OFF_W];
  if (WORDS > 1) begin : g_wsel
    assign st_wsel = st_addr[OFF_W-1:LANE_W];
  end else begin : g_wsel1
    assign st_wsel = '0;
  end

  assign empty = (count_q == '0);
  assign full  = (count_q == CNT_W'(DEPTH));

  wbuf_cam #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_st_cam (
    .clk(clk), .rst(rst), .live_i(slot_valid), .tags_i(slot_blk),
    .key_i(st_blk), .hit_o(st_hit)
  );
  wbuf_cam #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_rd_cam (
    .clk(clk), .rst(rst), .live_i(slot_valid), .tags_i(slot_blk),
    .key_i(rd_blk), .hit_o(rd_hit)
  );

  // arbitration: a read goes first when allowed, else the head entry drains
  always_comb begin
    cmd_free = !cmd_valid_q || mem_cmd_ready;
    rd_go    = rd_valid && cmd_free &&
               (cfg_drain_first ? empty : (rd_hit == '0));
    pop      = cmd_free && !rd_go && !empty;
    if (rd_go)    pick = PICK_READ;
    else if (pop) pick = PICK_WRITE;
    else          pick = PICK_NONE;
  end

  assign head_onehot = DEPTH'(1) << head_q;
  assign st_merge    = st_hit & ~(pop ? head_onehot : '0);
  assign merge_any   = (st_merge != '0);
  assign st_ready    = merge_any || !full;
  assign st_fire     = st_valid && st_ready;
  assign alloc       = st_fire && !merge_any;
  assign rd_ready    = rd_go;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    wbuf_slot #(.BLK_W(BLK_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_slot (
      .clk(clk), .rst(rst),
      .alloc_i(alloc && (tail_q == PTR_W'(i))),
      .merge_i(st_fire && st_merge[i]),
      .clear_i(pop && (head_q == PTR_W'(i))),
      .blk_i(st_blk), .wsel_i(st_wsel), .data_i(st_data), .be_i(st_be),
      .valid_o(slot_valid[i]), .blk_o(slot_blk[i]),
      .line_o(slot_line[i]), .mask_o(slot_mask[i])
    );
  end

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (pop)   head_q <= ptr_inc(head_q);
      if (alloc) tail_q <= ptr_inc(tail_q);
      count_q <= count_q + CNT_W'(alloc) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid_q <= 1'b0;
      cmd_write_q <= 1'b0;
      cmd_addr_q  <= '0;
      cmd_line_q  <= '0;
      cmd_mask_q  <= '0;
    end else begin
      unique case (pick)
        PICK_READ: begin
          cmd_valid_q <= 1'b1;
          cmd_write_q <= 1'b0;
          cmd_addr_q  <= rd_addr;
          cmd_line_q  <= '0;
          cmd_mask_q  <= '0;
        end
        PICK_WRITE: begin
          cmd_valid_q <= 1'b1;
          cmd_write_q <= 1'b1;
          cmd_addr_q  <= {slot_blk[head_q], OFF_W'(0)};
          cmd_line_q  <= slot_line[head_q];
          cmd_mask_q  <= slot_mask[head_q];
        end
        default: if (mem_cmd_ready) cmd_valid_q <= 1'b0;
      endcase
    end
  end

  assign mem_cmd_valid = cmd_valid_q;
  assign mem_cmd_write = cmd_write_q;
  assign mem_cmd_addr  = cmd_addr_q;
  assign mem_cmd_data  = cmd_line_q;
  assign mem_cmd_mask  = cmd_mask_q;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_write) && $stable(mem_cmd_addr) &&
       $stable(mem_cmd_data) && $stable(mem_cmd_mask))); // R6
  AST_RD_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready) |=> (mem_cmd_valid && !mem_cmd_write)); // R7
  AST_DRAIN_WAIT: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && cfg_drain_first) |-> (slot_valid == '0)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ready) |-> (slot_valid == '1)); // R10
  AST_POP_LIVE: assert property (@(posedge clk) disable iff (rst)
    pop |-> slot_valid[head_q]); // R6
endmodule

// File: tb/wbuf_merge_tb.sv
`timescale 1ns/1ps
module wbuf_merge_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_drain_first = 1'b0;
  logic         st_valid = 1'b0;
  logic         st_ready;
  logic [31:0]  st_addr = '0;
  logic [31:0]  st_data = '0;
  logic [3:0]   st_be = '0;
  logic         rd_valid = 1'b0;
  logic         rd_ready;
  logic [31:0]  rd_addr = '0;
  logic         mem_cmd_valid;
  logic         mem_cmd_ready = 1'b0;
  logic         mem_cmd_write;
  logic [31:0]  mem_cmd_addr;
  logic [127:0] mem_cmd_data;
  logic [15:0]  mem_cmd_mask;

  always #2 clk = ~clk;

  wbuf_merge dut_i (
    .clk(clk), .rst(rst), .cfg_drain_first(cfg_drain_first),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
    .mem_cmd_data(mem_cmd_data), .mem_cmd_mask(mem_cmd_mask)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // behavioural model
  logic [27:0]  q_blk[$];
  logic [127:0] q_line[$];
  logic [15:0]  q_mask[$];
  logic         m_cv = 1'b0, m_cw = 1'b0;
  logic [31:0]  m_ca = '0;
  logic [127:0] m_cd = '0;
  logic [15:0]  m_cm = '0;
  bit           st_pend = 1'b0, rd_pend = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [159:0] act, input logic [159:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic merge_bytes(inout logic [127:0] line, inout logic [15:0] mask,
                             input logic [31:0] a, input logic [31:0] d,
                             input logic [3:0] be);
    int w = int'(a[3:2]);
    for (int b = 0; b < 4; b++) begin
      if (be[b]) begin
        line[w*32 + b*8 +: 8] = d[b*8 +: 8];
        mask[w*4 + b] = 1'b1;
      end
    end
  endtask

  task automatic run_cycle(input bit mode, input int st_pct, input int mr_pct, input int rd_pct);
    bit free, conf, rd_ok, pop, exp_st_ready, st_fire;
    int hit_idx;
    string rtag;
    @(negedge clk);
    cfg_drain_first = mode;
    if (!st_pend && ($urandom % 100) < st_pct) begin
      st_pend = 1'b1;
      st_addr = {28'h0000100 + 28'($urandom % 5), 4'($urandom)};
      st_data = $urandom;
      st_be   = 4'($urandom);
    end
    if (!rd_pend && ($urandom % 100) < rd_pct) begin
      rd_pend = 1'b1;
      rd_addr = {28'h0000100 + 28'($urandom % 5), 4'($urandom)};
    end
    st_valid      = st_pend;
    rd_valid      = rd_pend;
    mem_cmd_ready = (($urandom % 100) < mr_pct);
    #1;
    free = !m_cv || mem_cmd_ready;
    conf = 1'b0;
    foreach (q_blk[i]) if (q_blk[i] == rd_addr[31:4]) conf = 1'b1;
    rd_ok = rd_valid && free && (mode ? (q_blk.size() == 0) : !conf);
    pop   = free && !rd_ok && (q_blk.size() > 0);
    hit_idx = -1;
    foreach (q_blk[i]) if (q_blk[i] == st_addr[31:4] && !(pop && i == 0)) hit_idx = i;
    exp_st_ready = (hit_idx >= 0) || (q_blk.size() < 4);
    // compare handshakes (same cycle) and command port (registered)
    chk(exp_st_ready ? "R2" : "R10", "st_ready", 160'(st_ready), 160'(exp_st_ready));
    rtag = mode ? "R9" : (conf ? "R8" : "R7");
    chk(rtag, "rd_ready", 160'(rd_ready), 160'(rd_valid && rd_ok));
    chk("R6", "mem_cmd_valid", 160'(mem_cmd_valid), 160'(m_cv));
    if (m_cv) begin
      rtag = m_cw ? "R3/R4/R5/R6" : "R7";
      chk(rtag, "mem_cmd_write", 160'(mem_cmd_write), 160'(m_cw));
      chk(rtag, "mem_cmd_addr", 160'(mem_cmd_addr), 160'(m_ca));
      chk(rtag, "mem_cmd_data/mask", {mem_cmd_data, 16'h0, mem_cmd_mask},
          {m_cd, 16'h0, m_cm});
    end
    // advance model
    st_fire = st_valid && exp_st_ready;
    if (m_cv && mem_cmd_ready) m_cv = 1'b0;
    if (rd_ok) begin
      m_cv = 1'b1; m_cw = 1'b0; m_ca = rd_addr; m_cd = '0; m_cm = '0;
      rd_pend = 1'b0;
    end else if (pop) begin
      m_cv = 1'b1; m_cw = 1'b1; m_ca = {q_blk[0], 4'h0}; m_cd = q_line[0]; m_cm = q_mask[0];
    end
    if (st_fire && hit_idx >= 0) begin
      logic [127:0] l = q_line[hit_idx];
      logic [15:0]  m = q_mask[hit_idx];
      merge_bytes(l, m, st_addr, st_data, st_be);
      q_line[hit_idx] = l;
      q_mask[hit_idx] = m;
    end
    if (pop) begin
      void'(q_blk.pop_front()); void'(q_line.pop_front()); void'(q_mask.pop_front());
    end
    if (st_fire && hit_idx < 0) begin
      logic [127:0] l = '0;
      logic [15:0]  m = '0;
      merge_bytes(l, m, st_addr, st_data, st_be);
      q_blk.push_back(st_addr[31:4]); q_line.push_back(l); q_mask.push_back(m);
    end
    if (st_fire) st_pend = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", "st_ready after reset", 160'(st_ready), 160'(1));
    chk("R1", "mem_cmd_valid after reset", 160'(mem_cmd_valid), 160'(0));
    chk("R1", "rd_ready after reset", 160'(rd_ready), 160'(0));
    for (int c = 0; c < 1500; c++) run_cycle(1'b0, 60, 50, 10);
    for (int c = 0; c < 1500; c++) run_cycle(1'b0, 85, 15, 15);
    for (int c = 0; c < 1500; c++) run_cycle(1'b1, 50, 60, 10);
    for (int c = 0; c < 1500; c++) run_cycle(1'b0, 30, 90, 20);
    for (int c = 0; c < 1500; c++) run_cycle(1'b1, 90, 20, 20);
    for (int c = 0; c < 40; c++)   run_cycle(1'b0, 0, 100, 0);
    chk("R6", "buffer drained at end", 160'(q_blk.size()), 160'(0));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R6 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule